// File: doc/BRIEF.md
# Parallel Peripheral Bus Phase Sequencer

This block steps a shared 8-bit peripheral bus through the phases of one command. Up to eight IDs (0 to 7) can ask for the bus while it is idle. The highest requesting ID becomes the initiator and names a target. The sequencer then runs a fixed chain of phases: identify message from the initiator, a six-byte command, an optional data phase, a status byte, and a closing message. After that the bus goes idle again.

Every byte moves with one req/ack pair. The sequencer raises `req`. The initiator answers with `ack` and, for outbound bytes, puts the byte on `bus_in`. The sequencer drops `req`, and the next step waits until `ack` is low again. Outbound bytes (identify, command, write data) come out on `rx_byte`/`rx_valid`. Inbound bytes (read data from `din`, the status code, and message codes) are driven on `bus_out` with `bus_oe`.

A target that asks to disconnect after the command is released with save-pointer and disconnect messages. The transfer is then kept as a pending nexus. The target later takes the bus back through a reselection phase and finishes the data, status and completion steps.

Top module: `pbus_phase_seq`

## Requirements
- R1: After reset, `phase` is 0 (bus free), and `req`, `bus_oe`, `owner_id`, `cmd_cnt`, `data_cnt` and `nexus_pending` are all zero.
- R2: Arbitration starts only from bus free. When bus free sees a nonzero `arb_req` and no nexus is pending, `phase` is 1 (arbitration) in the next cycle. Arbitration lasts exactly one cycle and is followed by selection (2) or reselection (3).
- R3: During selection, `owner_id` holds the highest ID whose `arb_req` bit (bit i = ID i) was set in the bus-free cycle. `target_id` holds the `sel_tgt` value sampled in that same cycle.
- R4: A command without disconnect runs these phases, one after another:
  - message-out (4): one identify byte;
  - command (5): six bytes;
  - data, if any;
  - status (8): one byte;
  - message-in (9): one byte 0x00 for command complete;
  - then bus free.
- R5: Each byte uses one req/ack pair:
  - `req` falls only after `ack` has been seen high;
  - `req` never rises outside the byte phases 4 to 9;
  - `phase` changes only when `req` and `ack` are both low after the last byte of the phase.
- R6: Each byte taken from `bus_in` in message-out, command or data-out appears on `rx_byte`, with a one-cycle `rx_valid` pulse. `cmd_cnt` counts command bytes up to 6.
- R7: Command byte 4 is the transfer length and bit 1 of command byte 0 sets the direction (1 = data-out phase 6, 0 = data-in phase 7). A length of 0 skips the data phase and goes to status. `data_cnt` ends equal to the length.
- R8: In phases 7, 8 and 9, `bus_oe` is high and `bus_out` holds the byte being offered: `din` in data-in, `status_code` in status, and the message code in message-in. `bus_out` stays stable while `req` is high.
- R9: If `disc_req` is high when the last command byte completes and the length is nonzero, message-in sends 0x02 (save data pointer) and then 0x04 (disconnect). The bus then goes free with `nexus_pending` set. With a length of 0, `disc_req` has no effect.
- R10: While a nexus is pending:
  - `arb_req` is ignored and the bus stays free;
  - `resel_req` leads to arbitration and then reselection (3) with `owner_id` equal to the saved target;
  - message-in then sends identify, 0x80 ORed with the low three bits of the original identify byte;
  - the data, status and completion steps follow, and `nexus_pending` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_req | input | 8 | Per-ID bus request, bit i for ID i |
| sel_tgt | input | 3 | Target ID named by the requesting initiator |
| resel_req | input | 1 | Disconnected target asks to resume |
| disc_req | input | 1 | Target asks to disconnect after the command |
| ack | input | 1 | Initiator byte acknowledge |
| bus_in | input | 8 | Byte driven by the initiator |
| din | input | 8 | Target read data for the current data byte |
| status_code | input | 8 | Status byte to return |
| phase | output | 4 | Current bus phase code |
| req | output | 1 | Byte request strobe |
| bus_oe | output | 1 | Sequencer drives `bus_out` |
| bus_out | output | 8 | Inbound byte offered to the initiator |
| owner_id | output | 3 | ID that won the last arbitration |
| target_id | output | 3 | Target of the current nexus |
| cmd_cnt | output | 3 | Command bytes received |
| data_cnt | output | 8 | Data bytes moved |
| rx_byte | output | 8 | Last outbound byte taken |
| rx_valid | output | 1 | One-cycle pulse with `rx_byte` |
| nexus_pending | output | 1 | A disconnected transfer awaits reselection |

## Verification
A wrong phase register shows up on the first byte of the next phase. That `req` rise carries the wrong phase code or a wrong `bus_out` byte, so a scoreboard of expected (phase, byte) pairs catches it within one handshake. A wrong byte or length counter either cuts a phase short or stretches it. Either way the expected item sequence shifts, and the mismatch is visible at the very next `req` rise. An arbitration error is visible in the single selection cycle through `owner_id`. A lost or stuck pending flag shows within the next few cycles: the bus either refuses `arb_req`, or ignores a reselection that should proceed.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [3:0] {
    PH_FREE  = 4'd0,
    PH_ARB   = 4'd1,
    PH_SEL   = 4'd2,
    PH_RESEL = 4'd3,
    PH_MSGO  = 4'd4,
    PH_CMD   = 4'd5,
    PH_DOUT  = 4'd6,
    PH_DIN   = 4'd7,
    PH_STAT  = 4'd8,
    PH_MSGI  = 4'd9
  } phase_e;

  // which message-in sequence is being sent
  typedef enum logic [1:0] {
    MI_DONE  = 2'd0,
    MI_DISC  = 2'd1,
    MI_RESEL = 2'd2
  } msgi_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_LOW  = 2'd2
  } hs_e;

  localparam logic [7:0] MSG_COMPLETE = 8'h00;
  localparam logic [7:0] MSG_SAVEPTR  = 8'h02;
  localparam logic [7:0] MSG_DISCON   = 8'h04;
  localparam logic [7:0] MSG_IDENT    = 8'h80;
endpackage

// File: rtl/pbus_id_arb.sv
module pbus_id_arb #(
  parameter int ID_W = 3
) (
  input  logic [(1<<ID_W)-1:0] req_vec,
  output logic [ID_W-1:0]      win,
  output logic                 any
);
  localparam int N_ID = 1 << ID_W;

  // later (higher) indices overwrite earlier ones: highest ID wins
  always_comb begin
    win = '0;
    for (int i = 0; i < N_ID; i++) begin
      if (req_vec[i]) win = ID_W'(i);
    end
  end

  assign any = |req_vec;
endmodule

// File: rtl/pbus_strobe.sv
module pbus_strobe
  import pbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic take,
  output logic done,
  output logic idle
);
  hs_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= HS_IDLE;
    end else begin
      unique case (st)
        HS_IDLE: if (start) st <= HS_REQ;
        HS_REQ:  if (ack)   st <= HS_LOW;
        HS_LOW:  if (!ack)  st <= HS_IDLE;
        default:            st <= HS_IDLE;
      endcase
    end
  end

  assign req  = (st == HS_REQ);
  assign take = (st == HS_REQ) && ack;
  assign done = (st == HS_LOW) && !ack;
  assign idle = (st == HS_IDLE);
endmodule

// File: rtl/pbus_cmd_store.sv
module pbus_cmd_store #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 6,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [DEPTH*BYTE_W-1:0] q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                          q[g*BYTE_W +: BYTE_W] <= '0;
      else if (we && idx == IDX_W'(g))  q[g*BYTE_W +: BYTE_W] <= wdata;
    end
  end
endmodule

// File: rtl/pbus_phase_seq.sv
module pbus_phase_seq
  import pbus_pkg::*;
#(
  parameter int ID_W      = 3,
  parameter int BYTE_W    = 8,
  parameter int CMD_BYTES = 6,
  parameter int LEN_POS   = 4,   // must precede the last command byte
  parameter int DIR_POS   = 1,
  parameter int LUN_W     = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [(1<<ID_W)-1:0]             arb_req,
  input  logic [ID_W-1:0]                  sel_tgt,
  input  logic                             resel_req,
  input  logic                             disc_req,
  input  logic                             ack,
  input  logic [BYTE_W-1:0]                bus_in,
  input  logic [BYTE_W-1:0]                din,
  input  logic [BYTE_W-1:0]                status_code,
  output logic [3:0]                       phase,
  output logic                             req,
  output logic                             bus_oe,
  output logic [BYTE_W-1:0]                bus_out,
  output logic [ID_W-1:0]                  owner_id,
  output logic [ID_W-1:0]                  target_id,
  output logic [$clog2(CMD_BYTES+1)-1:0]   cmd_cnt,
  output logic [BYTE_W-1:0]                data_cnt,
  output logic [BYTE_W-1:0]                rx_byte,
  output logic                             rx_valid,
  output logic                             nexus_pending
);
  localparam int N_ID  = 1 << ID_W;
  localparam int IDX_W = $clog2(CMD_BYTES);
  localparam int CC_W  = $clog2(CMD_BYTES+1);

  phase_e ph, ph_n;
  msgi_e  mkind, mk_n;

  logic [N_ID-1:0]             arb_snap;
  logic [ID_W-1:0]             arb_win;
  logic                        arb_any;
  logic [LUN_W-1:0]            lun;
  logic [BYTE_W-1:0]           bidx;
  logic [CMD_BYTES*BYTE_W-1:0] cmd_q;
  logic [BYTE_W-1:0]           xfer_len;
  logic                        wr_dir;
  logic                        byte_ph, in_dir, out_dir, last;
  logic                        hs_take, hs_done, hs_idle;
  logic [BYTE_W-1:0]           tx_mux;
  phase_e                      data_ph;

  assign phase    = ph;
  assign xfer_len = cmd_q[LEN_POS*BYTE_W +: BYTE_W];
  assign wr_dir   = cmd_q[DIR_POS];
  assign data_ph  = wr_dir ? PH_DOUT : PH_DIN;

  assign in_dir  = (ph == PH_DIN) || (ph == PH_STAT) || (ph == PH_MSGI);
  assign out_dir = (ph == PH_MSGO) || (ph == PH_CMD) || (ph == PH_DOUT);
  assign byte_ph = in_dir || out_dir;

  pbus_id_arb #(.ID_W(ID_W)) arb_i (
    .req_vec (arb_snap),
    .win     (arb_win),
    .any     (arb_any)
  );

  pbus_strobe strobe_i (
    .clk   (clk),
    .rst   (rst),
    .start (byte_ph),
    .ack   (ack),
    .req   (req),
    .take  (hs_take),
    .done  (hs_done),
    .idle  (hs_idle)
  );

  pbus_cmd_store #(.BYTE_W(BYTE_W), .DEPTH(CMD_BYTES), .IDX_W(IDX_W)) cmd_i (
    .clk   (clk),
    .rst   (rst),
    .we    (hs_take && ph == PH_CMD),
    .idx   (bidx[IDX_W-1:0]),
    .wdata (bus_in),
    .q     (cmd_q)
  );

  // last byte of the current phase
  always_comb begin
    unique case (ph)
      PH_CMD:          last = (bidx == BYTE_W'(CMD_BYTES-1));
      PH_DIN, PH_DOUT: last = ((data_cnt + BYTE_W'(1)) == xfer_len);
      PH_MSGI:         last = (mkind == MI_DISC) ? (bidx == BYTE_W'(1)) : 1'b1;
      default:         last = 1'b1;
    endcase
  end

  // inbound byte selection
  always_comb begin
    unique case (ph)
      PH_DIN:  tx_mux = din;
      PH_STAT: tx_mux = status_code;
      PH_MSGI: begin
        unique case (mkind)
          MI_DISC:  tx_mux = (bidx == '0) ? MSG_SAVEPTR : MSG_DISCON;
          MI_RESEL: tx_mux = MSG_IDENT | BYTE_W'(lun);
          default:  tx_mux = MSG_COMPLETE;
        endcase
      end
      default: tx_mux = '0;
    endcase
  end

  // phase sequencing
  always_comb begin
    ph_n = ph;
    mk_n = mkind;
    unique case (ph)
      PH_FREE: begin
        if (nexus_pending ? resel_req : (|arb_req)) ph_n = PH_ARB;
      end
      PH_ARB:   ph_n = nexus_pending ? PH_RESEL : PH_SEL;
      PH_SEL:   ph_n = PH_MSGO;
      PH_RESEL: begin
        ph_n = PH_MSGI;
        mk_n = MI_RESEL;
      end
      PH_MSGO: if (hs_done) ph_n = PH_CMD;
      PH_CMD: begin
        if (hs_done && last) begin
          if (xfer_len == '0) begin
            ph_n = PH_STAT;
          end else if (disc_req) begin
            ph_n = PH_MSGI;
            mk_n = MI_DISC;
          end else begin
            ph_n = data_ph;
          end
        end
      end
      PH_DIN, PH_DOUT: if (hs_done && last) ph_n = PH_STAT;
      PH_STAT: begin
        if (hs_done) begin
          ph_n = PH_MSGI;
          mk_n = MI_DONE;
        end
      end
      PH_MSGI: begin
        if (hs_done && last) ph_n = (mkind == MI_RESEL) ? data_ph : PH_FREE;
      end
      default: ph_n = PH_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph            <= PH_FREE;
      mkind         <= MI_DONE;
      bus_oe        <= 1'b0;
      bus_out       <= '0;
      arb_snap      <= '0;
      owner_id      <= '0;
      target_id     <= '0;
      cmd_cnt       <= '0;
      data_cnt      <= '0;
      bidx          <= '0;
      lun           <= '0;
      rx_byte       <= '0;
      rx_valid      <= 1'b0;
      nexus_pending <= 1'b0;
    end else begin
      ph     <= ph_n;
      mkind  <= mk_n;
      bus_oe <= (ph_n == PH_DIN) || (ph_n == PH_STAT) || (ph_n == PH_MSGI);

      if (ph == PH_FREE && ph_n == PH_ARB) begin
        arb_snap <= nexus_pending ? (N_ID'(1) << target_id) : arb_req;
        if (!nexus_pending) target_id <= sel_tgt;
      end
      if (ph == PH_ARB && arb_any) owner_id <= arb_win;

      if (ph == PH_SEL) begin
        cmd_cnt  <= '0;
        data_cnt <= '0;
      end
      if (ph == PH_RESEL) nexus_pending <= 1'b0;
      if (ph == PH_MSGI && hs_done && last && mkind == MI_DISC) nexus_pending <= 1'b1;

      if (hs_done) begin
        bidx <= last ? '0 : bidx + BYTE_W'(1);
        if (ph == PH_CMD) cmd_cnt <= cmd_cnt + CC_W'(1);
        if (ph == PH_DIN || ph == PH_DOUT) data_cnt <= data_cnt + BYTE_W'(1);
      end

      rx_valid <= hs_take && out_dir;
      if (hs_take && out_dir) rx_byte <= bus_in;
      if (hs_take && ph == PH_MSGO) lun <= bus_in[LUN_W-1:0];

      if (hs_idle && byte_ph) bus_out <= tx_mux;
    end
  end
endmodule

// File: rtl/pbus_phase_seq_chk.sv
module pbus_phase_seq_chk #(
  parameter int ID_W      = 3,
  parameter int BYTE_W    = 8,
  parameter int CMD_BYTES = 6
) (
  input logic                           clk,
  input logic                           rst,
  input logic [(1<<ID_W)-1:0]           arb_req,
  input logic [3:0]                     phase,
  input logic                           req,
  input logic                           ack,
  input logic [BYTE_W-1:0]              bus_out,
  input logic [ID_W-1:0]                owner_id,
  input logic [$clog2(CMD_BYTES+1)-1:0] cmd_cnt,
  input logic                           nexus_pending
);
  logic [(1<<ID_W)-1:0] arb_d1, arb_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      arb_d1 <= '0;
      arb_d2 <= '0;
    end else begin
      arb_d1 <= arb_req;
      arb_d2 <= arb_d1;
    end
  end

  assert_req_in_byte_phase_R5: assert property (@(posedge clk) disable iff (rst)
    req |-> (phase >= 4'd4 && phase <= 4'd9));

  assert_req_drop_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(ack));

  assert_phase_hold_in_xfer_R5: assert property (@(posedge clk) disable iff (rst)
    $past(req) |-> $stable(phase));

  assert_free_to_arb_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd0 && !nexus_pending && (|arb_req)) |=> phase == 4'd1);

  assert_arb_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    phase == 4'd1 |=> (phase == 4'd2 || phase == 4'd3));

  assert_highest_id_wins_R3: assert property (@(posedge clk) disable iff (rst)
    phase == 4'd2 |-> (arb_d2 >> owner_id) == 1);

  assert_cmd_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_cnt <= ($clog2(CMD_BYTES+1))'(CMD_BYTES));

  assert_no_select_pending_R10: assert property (@(posedge clk) disable iff (rst)
    nexus_pending |-> phase != 4'd2);

  assert_bus_out_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (req && $past(req)) |-> $stable(bus_out));
endmodule

bind pbus_phase_seq pbus_phase_seq_chk #(
  .ID_W(ID_W), .BYTE_W(BYTE_W), .CMD_BYTES(CMD_BYTES)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .arb_req       (arb_req),
  .phase         (phase),
  .req           (req),
  .ack           (ack),
  .bus_out       (bus_out),
  .owner_id      (owner_id),
  .cmd_cnt       (cmd_cnt),
  .nexus_pending (nexus_pending)
);

// File: tb/pbus_phase_seq_tb_top.sv
module pbus_phase_seq_tb_top;
  localparam logic [3:0] P_FREE = 4'd0, P_ARB = 4'd1, P_SEL = 4'd2, P_RESEL = 4'd3,
                         P_MSGO = 4'd4, P_CMD = 4'd5, P_DOUT = 4'd6, P_DIN = 4'd7,
                         P_STAT = 4'd8, P_MSGI = 4'd9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] arb_req = '0;
  logic [2:0] sel_tgt = '0;
  logic       resel_req = 1'b0, disc_req = 1'b0, ack = 1'b0;
  logic [7:0] bus_in = '0, status_code = '0;
  logic [7:0] din;
  logic [3:0] phase;
  logic       req, bus_oe, rx_valid, nexus_pending;
  logic [7:0] bus_out, data_cnt, rx_byte;
  logic [2:0] owner_id, target_id, cmd_cnt;

  int vecs = 0;
  int fails = 0;

  logic [11:0] exp_q[$];
  logic [7:0]  out_q[$];
  logic [7:0]  rx_q[$];

  always #4 clk = ~clk;

  assign din = 8'hC0 ^ data_cnt;

  pbus_phase_seq dut_i (
    .clk(clk), .rst(rst), .arb_req(arb_req), .sel_tgt(sel_tgt),
    .resel_req(resel_req), .disc_req(disc_req), .ack(ack), .bus_in(bus_in),
    .din(din), .status_code(status_code), .phase(phase), .req(req),
    .bus_oe(bus_oe), .bus_out(bus_out), .owner_id(owner_id),
    .target_id(target_id), .cmd_cnt(cmd_cnt), .data_cnt(data_cnt),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .nexus_pending(nexus_pending)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // monitor and initiator responder, one process so ack ordering is fixed
  logic       prev_req = 1'b0, prev_ack = 1'b0;
  logic [3:0] prev_ph = 4'd0;
  always @(negedge clk) begin
    logic [11:0] it;
    if (!rst) begin
      if (req && !prev_req) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected byte request in phase", phase, 0);
        end else begin
          it = exp_q.pop_front();
          check(phase == it[11:8], "R4", "phase at byte request", phase, it[11:8]);
          if (phase == P_DIN || phase == P_STAT || phase == P_MSGI) begin
            check(bus_oe, "R8", "bus_oe for inbound byte", bus_oe, 1);
            check(bus_out == it[7:0], "R8", "inbound byte", bus_out, it[7:0]);
          end
        end
      end
      if (rx_valid) begin
        if (rx_q.size() == 0) check(1'b0, "R6", "unexpected rx_valid", rx_byte, 0);
        else begin
          it[7:0] = rx_q.pop_front();
          check(rx_byte == it[7:0], "R6", "outbound byte", rx_byte, it[7:0]);
        end
      end
      if (prev_req && !req) check(prev_ack, "R5", "req fell without ack", prev_ack, 1);
      if (phase != prev_ph && prev_ph >= P_MSGO)
        check(!prev_ack && !req, "R5", "phase moved during handshake", {prev_ack, req}, 0);
      prev_req = req;
      prev_ph  = phase;
      if (req && !ack) begin
        if (phase == P_MSGO || phase == P_CMD || phase == P_DOUT)
          bus_in = (out_q.size() != 0) ? out_q.pop_front() : 8'h00;
        ack = 1'b1;
      end else if (!req && ack) begin
        ack = 1'b0;
      end
      prev_ack = ack;
    end
  end

  task automatic wait_ph(input logic [3:0] p);
    while (phase !== p) @(negedge clk);
  endtask

  task automatic push_out(input logic [3:0] p, input logic [7:0] b);
    exp_q.push_back({p, b});
    out_q.push_back(b);
    rx_q.push_back(b);
  endtask

  task automatic push_tail(input logic [7:0] op, input logic [7:0] len, input logic [7:0] st);
    for (int i = 0; i < len; i++) begin
      if (op[1]) push_out(P_DOUT, 8'h50 + 8'(i));
      else exp_q.push_back({P_DIN, 8'hC0 ^ 8'(i)});
    end
    exp_q.push_back({P_STAT, st});
    exp_q.push_back({P_MSGI, 8'h00});
  endtask

  task automatic run_cmd(input logic [7:0] mask, input logic [2:0] tgt, input logic [7:0] op,
                         input logic [7:0] len, input bit disc, input logic [7:0] st);
    logic [2:0] win;
    logic [7:0] ident;
    bit         dc;
    win = 0;
    for (int i = 0; i < 8; i++) if (mask[i]) win = 3'(i);
    ident = 8'h80 | {5'b0, tgt ^ 3'd7};
    dc = disc && (len != 0);
    push_out(P_MSGO, ident);
    push_out(P_CMD, op);
    push_out(P_CMD, 8'h01);
    push_out(P_CMD, 8'h02);
    push_out(P_CMD, 8'h03);
    push_out(P_CMD, len);
    push_out(P_CMD, 8'h00);
    if (dc) begin
      exp_q.push_back({P_MSGI, 8'h02});
      exp_q.push_back({P_MSGI, 8'h04});
    end else begin
      push_tail(op, len, st);
    end
    arb_req = mask; sel_tgt = tgt; disc_req = disc; status_code = st;
    wait_ph(P_ARB);
    arb_req = 8'h00;
    wait_ph(P_SEL);
    check(owner_id == win, "R3", "winning ID", owner_id, win);
    check(target_id == tgt, "R3", "target ID", target_id, tgt);
    wait_ph(P_FREE);
    disc_req = 1'b0;
    check(cmd_cnt == 3'd6, "R6", "command byte count", cmd_cnt, 6);
    check(data_cnt == (dc ? 8'd0 : len), "R7", "data byte count", data_cnt, dc ? 0 : len);
    check(nexus_pending == dc, "R9", "pending after command", nexus_pending, dc);
    check(exp_q.size() == 0, "R4", "items left after command", exp_q.size(), 0);
  endtask

  task automatic run_resel(input logic [2:0] tgt, input logic [7:0] op,
                           input logic [7:0] len, input logic [7:0] st);
    exp_q.push_back({P_MSGI, 8'h80 | {5'b0, tgt ^ 3'd7}});
    push_tail(op, len, st);
    status_code = st;
    // R10: requests from initiators are ignored while the nexus is pending
    arb_req = 8'hFF;
    repeat (6) @(negedge clk);
    check(phase == P_FREE, "R10", "bus stays free with arb_req while pending", phase, P_FREE);
    arb_req = 8'h00;
    resel_req = 1'b1;
    wait_ph(P_ARB);
    resel_req = 1'b0;
    @(negedge clk);
    check(phase == P_RESEL, "R10", "reselection phase", phase, P_RESEL);
    check(owner_id == tgt, "R10", "reselecting owner", owner_id, tgt);
    wait_ph(P_FREE);
    check(nexus_pending == 1'b0, "R10", "pending cleared", nexus_pending, 0);
    check(data_cnt == len, "R7", "data count after resume", data_cnt, len);
    check(exp_q.size() == 0, "R10", "items left after resume", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(phase == P_FREE, "R1", "reset phase", phase, 0);
    check(!req && !bus_oe, "R1", "reset req/oe", {req, bus_oe}, 0);
    check(owner_id == 0 && cmd_cnt == 0 && data_cnt == 0, "R1", "reset counters",
          {owner_id, cmd_cnt, data_cnt}, 0);
    check(!nexus_pending, "R1", "reset pending", nexus_pending, 0);
    repeat (3) @(negedge clk);
    check(phase == P_FREE, "R2", "idle without request", phase, P_FREE);

    run_cmd(8'h05, 3'd3, 8'h08, 8'd4, 1'b0, 8'h00);   // R4 read, R3 winner 2
    run_cmd(8'h81, 3'd1, 8'h0A, 8'd3, 1'b0, 8'h02);   // R7 write, winner 7
    run_cmd(8'h7E, 3'd0, 8'h08, 8'd0, 1'b1, 8'h08);   // R7 zero length, R9 disc ignored
    run_cmd(8'h10, 3'd6, 8'h08, 8'd2, 1'b1, 8'h00);   // R9 disconnect
    run_resel(3'd6, 8'h08, 8'd2, 8'h00);              // R10
    run_cmd(8'h42, 3'd5, 8'h0A, 8'd2, 1'b1, 8'h18);   // R9 disconnect on write
    run_resel(3'd5, 8'h0A, 8'd2, 8'h18);              // R10

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule